// File: doc/BRIEF.md
# Burst SRAM Address Control Unit

This block is the address front end of a synchronous pipelined burst SRAM. On every rising clock edge it samples two active-low address strobes: a processor strobe and a controller strobe. It also samples an active-low burst-advance input, three chip enables and a burst-order select pin. From these it decides whether to start a new access cycle, close the current cycle, step the burst, or hold.

When a cycle starts, the external address is loaded into an internal base register and a 2-bit burst counter is cleared. Each accepted advance steps the counter. The two least significant bits of the array address then follow either a linear sequence (add modulo 4) or an interleaved sequence (start bits XOR count). The order is latched when the cycle starts. The upper address bits never change within a burst.

The datapath reads three outputs:
- the array address;
- a cycle-valid flag;
- a one-cycle start pulse.

All are registered, so each reflects the inputs sampled on the previous rising edge.

The chip enables are named `ce_main_n` (active low), `ce_hi` (active high) and `ce_lo_n` (active low). `ce_hi` and `ce_lo_n` together are called the secondary enables.

Top module: `sram_addr_ctl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises with no strobe asserted, `arr_addr` is 0 and both `cyc_valid` and `cyc_start` are 0.
- R2: A processor start occurs when `pstb_n`=0, `ce_main_n`=0, `ce_hi`=1 and `ce_lo_n`=0 are sampled together. After that edge, `arr_addr` equals the sampled `addr_in`, `cyc_valid`=1 and `cyc_start`=1. `cstb_n` and `adv_n` have no effect on that edge.
- R3: A controller start occurs when `cstb_n`=0, `pstb_n`=1, `ce_hi`=1 and `ce_lo_n`=0 are sampled, whatever the value of `ce_main_n`. The outputs then load exactly as in R2.
- R4: If `pstb_n`=0 and `ce_main_n`=1 are sampled together, the edge is ignored completely. `arr_addr`, `cyc_valid` and `cyc_start`=0 keep their values, even with `cstb_n`=0 and `adv_n`=0.
- R5: A strobe that would start a cycle while the secondary enables are inactive (`ce_hi`=0 or `ce_lo_n`=1) deselects. After that edge, `cyc_valid`=0 and `cyc_start`=0, and `arr_addr` is unchanged.
- R6: If `pstb_n`=1, `cstb_n`=1 and `adv_n`=0 are sampled while `cyc_valid`=1, the burst steps to its next address. Only `arr_addr[1:0]` changes and `cyc_start` is 0.
- R7: With `order_sel`=0 sampled at the start, the k-th address of the burst has low bits (start + k) mod 4.
- R8: With `order_sel`=1 sampled at the start, the k-th address of the burst has low bits start XOR (k mod 4).
- R9: `order_sel` is used only on a start edge. Changing it during a burst does not change the sequence.
- R10: With both strobes high and `adv_n`=1, all outputs hold (`cyc_start` goes to 0). The burst is suspended and later resumes from where it stopped.
- R11: After four advances the burst wraps back to its start address.
- R12: An advance sampled while `cyc_valid`=0 does not change `arr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Master chip enable, active low; gates only the processor strobe |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| arr_addr | output | ADDR_W | Current array address |
| cyc_valid | output | 1 | An access cycle is open |
| cyc_start | output | 1 | Pulses for one cycle after a start edge |

## Verification
The hardest situation to reach is an edge on which several strobes and enables conflict. One case is the processor strobe blocked by the master enable while the controller strobe and the advance input are both low: the edge must be ignored entirely rather than start a controller cycle or step the burst. Another is an advance arriving after a deselect. The stimulus first builds a burst at a known, non-zero address, then drives each conflicting combination on a single edge. It then checks that the address and flags are unchanged before any other edge occurs. Interleaved order is tested through a controller start with the master enable inactive. The order pin is then flipped partway through the burst to show that the latched order is kept.

// File: rtl/sram_actl_pkg.sv
package sram_actl_pkg;
    typedef enum logic [2:0] {
        CMD_HOLD   = 3'd0,
        CMD_LOAD   = 3'd1,
        CMD_DESEL  = 3'd2,
        CMD_ADV    = 3'd3,
        CMD_IGNORE = 3'd4
    } actl_cmd_e;
endpackage

// File: rtl/actl_strobe_dec.sv
module actl_strobe_dec
    import sram_actl_pkg::*;
(
    input  logic      pstb_n,
    input  logic      cstb_n,
    input  logic      adv_n,
    input  logic      ce_main_n,
    input  logic      ce_hi,
    input  logic      ce_lo_n,
    input  logic      valid,
    output actl_cmd_e cmd
);
    logic sec_en;
    logic p_req;
    logic p_blk;
    logic c_req;

    always_comb begin
        sec_en = ce_hi && !ce_lo_n;
        p_req  = !pstb_n && !ce_main_n;
        p_blk  = !pstb_n && ce_main_n;
        c_req  = pstb_n && !cstb_n;
        if (p_req || c_req) begin
            cmd = sec_en ? CMD_LOAD : CMD_DESEL;
        end else if (p_blk) begin
            cmd = CMD_IGNORE;
        end else if (!adv_n && valid) begin
            cmd = CMD_ADV;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // R4
    always_comb begin
        if (!pstb_n && ce_main_n) begin
            ce_main_blk_chk: assert (cmd == CMD_IGNORE)
                else $error("blocked processor strobe not ignored");
        end
    end
endmodule

// File: rtl/actl_burst_seq.sv
module actl_burst_seq #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_bits,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ileave,
    output logic [CNT_W-1:0] out_bits,
    output logic [CNT_W-1:0] cnt_next
);
    logic [CNT_W-1:0] lin_bits;
    logic [CNT_W-1:0] ilv_bits;

    always_comb begin
        lin_bits = start_bits + cnt;
        cnt_next = cnt + 1'b1;
    end

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        always_comb ilv_bits[b] = start_bits[b] ^ cnt[b];
    end

    always_comb out_bits = ileave ? ilv_bits : lin_bits;

    // R7 R8
    always_comb begin
        if (cnt == '0) begin
            first_beat_chk: assert (out_bits == start_bits)
                else $error("first burst beat differs from start bits");
        end
    end
endmodule

// File: rtl/sram_addr_ctl.sv
module sram_addr_ctl
    import sram_actl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              ce_main_n,
    input  logic              ce_hi,
    input  logic              ce_lo_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              cyc_valid,
    output logic              cyc_start
);
    localparam int UP_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic              ileave;
        logic              valid;
        logic              start;
    } actl_state_t;

    actl_state_t st_d, st_q;
    actl_cmd_e   cmd;
    logic [CNT_W-1:0] low_bits;
    logic [CNT_W-1:0] cnt_inc;

    actl_strobe_dec u_dec (
        .pstb_n    (pstb_n),
        .cstb_n    (cstb_n),
        .adv_n     (adv_n),
        .ce_main_n (ce_main_n),
        .ce_hi     (ce_hi),
        .ce_lo_n   (ce_lo_n),
        .valid     (st_q.valid),
        .cmd       (cmd)
    );

    actl_burst_seq #(.CNT_W(CNT_W)) u_seq (
        .start_bits (st_q.base[CNT_W-1:0]),
        .cnt        (st_q.cnt),
        .ileave     (st_q.ileave),
        .out_bits   (low_bits),
        .cnt_next   (cnt_inc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.base   = addr_in;
                st_d.cnt    = '0;
                st_d.ileave = order_sel;
                st_d.valid  = 1'b1;
                st_d.start  = 1'b1;
            end
            CMD_DESEL: st_d.valid = 1'b0;
            CMD_ADV:   st_d.cnt   = cnt_inc;
            CMD_IGNORE, CMD_HOLD: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        arr_addr  = {st_q.base[ADDR_W-1:CNT_W], low_bits};
        cyc_valid = st_q.valid;
        cyc_start = st_q.start;
    end

    // R2
    p_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !ce_main_n && ce_hi && !ce_lo_n)
        |=> (cyc_valid && cyc_start && arr_addr == $past(addr_in)))
        else $error("processor start not loaded");

    // R3
    c_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb_n && !cstb_n && ce_hi && !ce_lo_n)
        |=> (cyc_valid && cyc_start && arr_addr == $past(addr_in)))
        else $error("controller start not loaded");

    // R4
    p_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && ce_main_n)
        |=> ($stable(arr_addr) && $stable(cyc_valid) && !cyc_start))
        else $error("blocked strobe changed state");

    // R5
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((!pstb_n && !ce_main_n) || (pstb_n && !cstb_n)) && !(ce_hi && !ce_lo_n))
        |=> (!cyc_valid && !cyc_start && $stable(arr_addr)))
        else $error("deselect failed");

    // R6
    adv_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb_n && cstb_n && !adv_n && cyc_valid)
        |=> (arr_addr[ADDR_W-1:CNT_W] == $past(arr_addr[ADDR_W-1:CNT_W])
             && arr_addr[CNT_W-1:0] != $past(arr_addr[CNT_W-1:0]) && !cyc_start))
        else $error("advance altered wrong bits");

    // R10 R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb_n && cstb_n && (adv_n || !cyc_valid))
        |=> ($stable(arr_addr) && $stable(cyc_valid) && !cyc_start))
        else $error("idle edge changed state");

    initial begin
        width_chk: assert (UP_W > 0) else $error("address too narrow");
    end
endmodule

// File: tb/sim_sram_addr_ctl.sv
module sim_sram_addr_ctl;
    localparam int  AW     = 20;
    localparam time CLK_PS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
    logic ce_main_n = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] arr_addr;
    logic cyc_valid, cyc_start;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PS/2) clk = ~clk;

    sram_addr_ctl #(.ADDR_W(AW), .CNT_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .pstb_n(pstb_n),
        .cstb_n(cstb_n), .adv_n(adv_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi),
        .ce_lo_n(ce_lo_n), .order_sel(order_sel), .arr_addr(arr_addr),
        .cyc_valid(cyc_valid), .cyc_start(cyc_start)
    );

    task automatic chk(string req, logic [AW-1:0] ea, logic ev, logic es);
        n_vec++;
        if (arr_addr !== ea || cyc_valid !== ev || cyc_start !== es) begin
            n_bad++;
            $display("FAIL %s: addr=%h valid=%b start=%b expected addr=%h valid=%b start=%b",
                     req, arr_addr, cyc_valid, cyc_start, ea, ev, es);
        end
    endtask

    // drive one edge worth of inputs, then wait to a falling edge past it
    task automatic edge_in(logic p, logic c, logic a, logic e0, logic e1, logic e2,
                           logic ord, logic [AW-1:0] ad);
        pstb_n = p; cstb_n = c; adv_n = a; ce_main_n = e0; ce_hi = e1;
        ce_lo_n = e2; order_sel = ord; addr_in = ad;
        @(negedge clk);
    endtask

    task automatic idle_edge(logic a);
        edge_in(1, 1, a, 0, 1, 0, order_sel, addr_in);
    endtask

    function automatic logic [AW-1:0] bexp(logic [AW-1:0] s, int k, logic ilv);
        logic [1:0] lo;
        lo = ilv ? (s[1:0] ^ 2'(k % 4)) : 2'((s[1:0] + k) % 4);
        return {s[AW-1:2], lo};
    endfunction

    task automatic t_reset();
        chk("R1 in reset", '0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        idle_edge(1);
        chk("R1 after reset", '0, 0, 0);
    endtask

    task automatic t_proc_start();
        logic [AW-1:0] a = 20'hA5C36;
        edge_in(0, 0, 0, 0, 1, 0, 0, a);
        chk("R2 processor start", a, 1, 1);
        idle_edge(1);
        chk("R10 hold after start", a, 1, 0);
    endtask

    task automatic t_linear();
        logic [AW-1:0] a = 20'h3F1E2;
        edge_in(0, 1, 1, 0, 1, 0, 0, a);
        chk("R2 linear start", a, 1, 1);
        for (int k = 1; k <= 4; k++) begin
            idle_edge(0);
            chk(k == 4 ? "R11 linear wrap" : "R7 linear step", bexp(a, k, 0), 1, 0);
        end
        idle_edge(0);
        chk("R6 step after wrap", bexp(a, 1, 0), 1, 0);
    endtask

    task automatic t_interleave();
        logic [AW-1:0] a = 20'h12341;
        edge_in(1, 0, 1, 1, 1, 0, 1, a);
        chk("R3 controller start with master enable off", a, 1, 1);
        idle_edge(0);
        chk("R8 interleave k1", bexp(a, 1, 1), 1, 0);
        order_sel = 1'b0;
        idle_edge(0);
        chk("R9 order change ignored", bexp(a, 2, 1), 1, 0);
        idle_edge(1);
        chk("R10 suspend", bexp(a, 2, 1), 1, 0);
        idle_edge(1);
        chk("R10 suspend 2", bexp(a, 2, 1), 1, 0);
        idle_edge(0);
        chk("R8 interleave resume k3", bexp(a, 3, 1), 1, 0);
        idle_edge(0);
        chk("R11 interleave wrap", a, 1, 0);
    endtask

    task automatic t_block();
        logic [AW-1:0] a = 20'h0BEE3;
        edge_in(0, 1, 1, 0, 1, 0, 0, a);
        chk("R2 start before block", a, 1, 1);
        idle_edge(0);
        chk("R7 step before block", bexp(a, 1, 0), 1, 0);
        edge_in(0, 0, 0, 1, 1, 0, 1, 20'h55555);
        chk("R4 blocked strobe ignored", bexp(a, 1, 0), 1, 0);
    endtask

    task automatic t_desel();
        logic [AW-1:0] a = 20'h7C0D2;
        edge_in(0, 1, 1, 0, 1, 0, 0, a);
        chk("R2 start before deselect", a, 1, 1);
        edge_in(0, 1, 0, 0, 0, 0, 0, 20'h11111);
        chk("R5 processor deselect", a, 0, 0);
        idle_edge(0);
        chk("R12 advance while idle", a, 0, 0);
        edge_in(1, 0, 1, 0, 1, 1, 0, 20'h22222);
        chk("R5 controller deselect", a, 0, 0);
        edge_in(1, 0, 1, 1, 1, 0, 0, 20'h33330);
        chk("R3 restart after deselect", 20'h33330, 1, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_proc_start();
        t_linear();
        t_interleave();
        t_block();
        t_desel();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule